// File: doc/BRIEF.md
# Counted Host Read-Transfer Controller

This block sends a preset number of bytes from a buffer memory to a host port. A host that answers requests one byte at a time paces the transfer. A control microprocessor programs three things through a small byte-wide register window: a 16-bit byte count, held in two byte registers, and a buffer start address. It then writes a start command. The block fetches the first byte from the buffer's synchronous read port, latches it onto the host data bus and raises a data-request line.

The host answers each request with a read strobe, much as a DMA controller would. The block drops the request while the strobe is high. When the strobe ends, it steps the address up by one and the remaining count down by one. It then fetches the next byte and requests again. During the strobe for the final byte an end-of-process line is high. When that strobe ends, the block clears its transfer-enable flag and raises a completion interrupt. The interrupt stays set until the microprocessor acknowledges it. A start command with a zero count finishes at once.

Top module: `hxfer_ctrl`

## Requirements
- R1: After reset, the remaining count and the address read back as zero, and `host_drq`, `host_eop`, `xfer_en` and `irq` are all low. Microprocessor register offsets are as follows. 0 is count low byte and 1 is count high byte. 2 is address low byte and 3 is address high byte. 4 is command; writing bit 0 = 1 starts a transfer. 5 is status; bit 0 is transfer-enable and bit 1 is the completion interrupt. Reads of offsets 0 to 3 return the live remaining count and current address.
- R2: A start with a non-zero count sets `xfer_en` on the next clock. `host_drq` rises within four clocks of the start write.
- R3: While `host_drq` is high and for the whole strobe that follows, `host_data` holds the buffer byte at the current address. Successive bytes come from ascending addresses, which wrap modulo 2^ADDR_W.
- R4: `host_drq` is low from the first clock after `host_rd` rises until the strobe ends. It rises again only if bytes remain, and stays low after the last byte.
- R5: On the clock after `host_rd` falls, the remaining count drops by one and the address rises by one.
- R6: `host_eop` is high while `host_rd` is high for the last counted byte, and low at all other times.
- R7: On the clock after the last strobe ends, `xfer_en` drops and `irq` rises. Status bit 0 reads 0 and status bit 1 reads 1.
- R8: `irq` stays high until a status write with bit 1 = 1 clears it. A status write with bit 1 = 0 leaves it set.
- R9: While a transfer is active, start commands and writes to offsets 0 to 3 are ignored. The remaining count and the address read back unchanged, and the bytes delivered still follow the original address.
- R10: A start with a count of zero raises `irq` on the next clock. It never asserts `host_drq` and leaves `xfer_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_we | input | 1 | Microprocessor register write strobe |
| cpu_addr | input | 3 | Microprocessor register offset |
| cpu_wdata | input | 8 | Microprocessor write data |
| cpu_rdata | output | 8 | Microprocessor read data for `cpu_addr` |
| irq | output | 1 | Transfer-complete interrupt |
| xfer_en | output | 1 | Transfer-enable flag |
| buf_rd | output | 1 | Buffer read enable; data returns on the next clock |
| buf_addr | output | ADDR_W | Buffer read address |
| buf_rdata | input | 8 | Buffer read data |
| host_drq | output | 1 | Data request to the host |
| host_rd | input | 1 | Host read strobe, active high |
| host_eop | output | 1 | End of process, high during the last byte's strobe |
| host_data | output | 8 | Byte presented to the host |

## Verification
Transfers are run with random counts from one to nine, random start addresses, strobe widths of one to three clocks and random gaps before each strobe. These runs separate a correct address and count step from a step that is missed or doubled, whichever way the host paces the strobes. A run that starts just below the top of the address space shows whether the address wraps. A one-byte count shows whether end-of-process and completion fire on the first strobe. A zero count tells the immediate-finish path apart from a transfer that requests data. Register writes and restarts made in the middle of a transfer show whether the live count and address are protected. Interrupt acknowledges written with and without the clear bit show whether the interrupt holds until it is cleared.

// File: rtl/hxfer_pkg.sv
package hxfer_pkg;

  localparam int CNT_W = 16;

  localparam logic [2:0] OFS_CNT_LO = 3'd0;
  localparam logic [2:0] OFS_CNT_HI = 3'd1;
  localparam logic [2:0] OFS_ADR_LO = 3'd2;
  localparam logic [2:0] OFS_ADR_HI = 3'd3;
  localparam logic [2:0] OFS_CMD    = 3'd4;
  localparam logic [2:0] OFS_STAT   = 3'd5;

  localparam int CMD_GO_BIT  = 0;
  localparam int STAT_EN_BIT = 0;
  localparam int STAT_IRQ_BIT = 1;

  typedef enum logic [2:0] {
    XS_IDLE   = 3'd0,
    XS_FETCH  = 3'd1,
    XS_LATCH  = 3'd2,
    XS_READY  = 3'd3,
    XS_STROBE = 3'd4
  } xfer_state_t;

  // Replace one byte of a 16-bit register image.
  function automatic logic [15:0] merge_byte(input logic [15:0] cur,
                                             input logic [7:0] b,
                                             input logic upper);
    return upper ? {b, cur[7:0]} : {cur[15:8], b};
  endfunction

  // Remaining count after one byte has been taken.
  function automatic logic [CNT_W-1:0] count_after(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  // Pick one byte of a 16-bit value.
  function automatic logic [7:0] pick_byte(input logic [15:0] v, input logic upper);
    return upper ? v[15:8] : v[7:0];
  endfunction

endpackage

// File: rtl/hxfer_cpu_if.sv
module hxfer_cpu_if
  import hxfer_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              cpu_we,
  input  logic [2:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [ADDR_W-1:0] adr_q,
  input  logic              busy,
  input  logic              irq_flag,
  output logic              ld_cnt_lo,
  output logic              ld_cnt_hi,
  output logic              ld_adr_lo,
  output logic              ld_adr_hi,
  output logic              start_req,
  output logic              irq_clr,
  output logic [7:0]        cpu_rdata
);

  logic [15:0] adr_wide;
  logic [15:0] cnt_wide;

  assign adr_wide = 16'(adr_q);
  assign cnt_wide = 16'(cnt_q);

  assign ld_cnt_lo = cpu_we && (cpu_addr == OFS_CNT_LO);
  assign ld_cnt_hi = cpu_we && (cpu_addr == OFS_CNT_HI);
  assign ld_adr_lo = cpu_we && (cpu_addr == OFS_ADR_LO);
  assign ld_adr_hi = cpu_we && (cpu_addr == OFS_ADR_HI);
  assign start_req = cpu_we && (cpu_addr == OFS_CMD) && cpu_wdata[CMD_GO_BIT];
  assign irq_clr   = cpu_we && (cpu_addr == OFS_STAT) && cpu_wdata[STAT_IRQ_BIT];

  always_comb begin
    cpu_rdata = 8'h00;
    case (cpu_addr)
      OFS_CNT_LO: cpu_rdata = pick_byte(cnt_wide, 1'b0);
      OFS_CNT_HI: cpu_rdata = pick_byte(cnt_wide, 1'b1);
      OFS_ADR_LO: cpu_rdata = pick_byte(adr_wide, 1'b0);
      OFS_ADR_HI: cpu_rdata = pick_byte(adr_wide, 1'b1);
      OFS_STAT: begin
        cpu_rdata[STAT_EN_BIT]  = busy;
        cpu_rdata[STAT_IRQ_BIT] = irq_flag;
      end
      default: cpu_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/hxfer_counters.sv
module hxfer_counters
  import hxfer_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_cnt_lo,
  input  logic              ld_cnt_hi,
  input  logic              ld_adr_lo,
  input  logic              ld_adr_hi,
  input  logic [7:0]        wdata,
  input  logic              busy,
  input  logic              step,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [ADDR_W-1:0] adr_q,
  output logic              cnt_zero,
  output logic              cnt_last
);

  logic [15:0] adr_img;
  logic        load_ok;

  assign adr_img  = 16'(adr_q);
  assign load_ok  = !busy;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= count_after(cnt_q);
    end else if (load_ok && ld_cnt_lo) begin
      cnt_q <= CNT_W'(merge_byte(16'(cnt_q), wdata, 1'b0));
    end else if (load_ok && ld_cnt_hi) begin
      cnt_q <= CNT_W'(merge_byte(16'(cnt_q), wdata, 1'b1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q <= '0;
    end else if (step) begin
      adr_q <= adr_q + ADDR_W'(1);
    end else if (load_ok && ld_adr_lo) begin
      adr_q <= ADDR_W'(merge_byte(adr_img, wdata, 1'b0));
    end else if (load_ok && ld_adr_hi) begin
      adr_q <= ADDR_W'(merge_byte(adr_img, wdata, 1'b1));
    end
  end

endmodule

// File: rtl/hxfer_seq.sv
module hxfer_seq
  import hxfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       irq_clr,
  input  logic       cnt_zero,
  input  logic       cnt_last,
  input  logic       host_rd,
  input  logic [7:0] buf_rdata,
  output logic       busy,
  output logic       buf_rd,
  output logic [7:0] host_data,
  output logic       host_drq,
  output logic       host_eop,
  output logic       start_evt,
  output logic       step_evt,
  output logic       done_evt,
  output logic       irq_flag
);

  xfer_state_t state_q;
  xfer_state_t state_d;

  assign busy      = (state_q != XS_IDLE);
  assign buf_rd    = (state_q == XS_FETCH);
  assign host_drq  = (state_q == XS_READY);
  assign start_evt = start_req && (state_q == XS_IDLE);
  assign step_evt  = (state_q == XS_STROBE) && !host_rd;
  assign done_evt  = (start_evt && cnt_zero) || (step_evt && cnt_last);
  assign host_eop  = host_rd && cnt_last &&
                     ((state_q == XS_READY) || (state_q == XS_STROBE));

  always_comb begin
    state_d = state_q;
    case (state_q)
      XS_IDLE:   if (start_evt && !cnt_zero) state_d = XS_FETCH;
      XS_FETCH:  state_d = XS_LATCH;
      XS_LATCH:  state_d = XS_READY;
      XS_READY:  if (host_rd) state_d = XS_STROBE;
      XS_STROBE: if (!host_rd) state_d = cnt_last ? XS_IDLE : XS_FETCH;
      default:   state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_data <= 8'h00;
    end else if (state_q == XS_LATCH) begin
      host_data <= buf_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
    end else if (done_evt) begin
      irq_flag <= 1'b1;
    end else if (irq_clr) begin
      irq_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/hxfer_ctrl.sv
module hxfer_ctrl
  import hxfer_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [2:0]        cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic [7:0]        cpu_rdata,
  output logic              irq,
  output logic              xfer_en,
  output logic              buf_rd,
  output logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_rdata,
  output logic              host_drq,
  input  logic              host_rd,
  output logic              host_eop,
  output logic [7:0]        host_data
);

  logic              ld_cnt_lo;
  logic              ld_cnt_hi;
  logic              ld_adr_lo;
  logic              ld_adr_hi;
  logic              start_req;
  logic              irq_clr;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] adr_q;
  logic              cnt_zero;
  logic              cnt_last;
  logic              busy;
  logic              start_evt;
  logic              step_evt;
  logic              done_evt;
  logic              irq_flag;

  hxfer_cpu_if #(.ADDR_W(ADDR_W)) u_cpu (
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cnt_q     (cnt_q),
    .adr_q     (adr_q),
    .busy      (busy),
    .irq_flag  (irq_flag),
    .ld_cnt_lo (ld_cnt_lo),
    .ld_cnt_hi (ld_cnt_hi),
    .ld_adr_lo (ld_adr_lo),
    .ld_adr_hi (ld_adr_hi),
    .start_req (start_req),
    .irq_clr   (irq_clr),
    .cpu_rdata (cpu_rdata)
  );

  hxfer_counters #(.ADDR_W(ADDR_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_cnt_lo (ld_cnt_lo),
    .ld_cnt_hi (ld_cnt_hi),
    .ld_adr_lo (ld_adr_lo),
    .ld_adr_hi (ld_adr_hi),
    .wdata     (cpu_wdata),
    .busy      (busy),
    .step      (step_evt),
    .cnt_q     (cnt_q),
    .adr_q     (adr_q),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last)
  );

  hxfer_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .irq_clr   (irq_clr),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .host_rd   (host_rd),
    .buf_rdata (buf_rdata),
    .busy      (busy),
    .buf_rd    (buf_rd),
    .host_data (host_data),
    .host_drq  (host_drq),
    .host_eop  (host_eop),
    .start_evt (start_evt),
    .step_evt  (step_evt),
    .done_evt  (done_evt),
    .irq_flag  (irq_flag)
  );

  assign buf_addr = adr_q;
  assign irq      = irq_flag;
  assign xfer_en  = busy;

endmodule

// File: rtl/hxfer_chk.sv
module hxfer_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd,
  input logic              host_drq,
  input logic              host_eop,
  input logic [15:0]       cnt_q,
  input logic [ADDR_W-1:0] adr_q,
  input logic              busy,
  input logic              irq_flag,
  input logic              irq_clr,
  input logic              start_evt,
  input logic              step_evt,
  input logic              done_evt
);

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && cnt_q != 16'd0) |=> busy);

  // R4
  drq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_drq && host_rd) |=> !host_drq);

  // R5
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (cnt_q == $past(cnt_q) - 16'd1) && (adr_q == $past(adr_q) + ADDR_W'(1)));

  // R6
  eop_last_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_eop |-> (cnt_q == 16'd1) && host_rd);

  // R7
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && !start_evt) |=> irq_flag && !busy && !host_drq);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_evt) |=> $stable(cnt_q) && $stable(adr_q));

  // R10
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && cnt_q == 16'd0) |=> irq_flag && !busy && !host_drq);

endmodule

bind hxfer_ctrl hxfer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_rd   (host_rd),
  .host_drq  (host_drq),
  .host_eop  (host_eop),
  .cnt_q     (cnt_q),
  .adr_q     (adr_q),
  .busy      (busy),
  .irq_flag  (irq_flag),
  .irq_clr   (irq_clr),
  .start_evt (start_evt),
  .step_evt  (step_evt),
  .done_evt  (done_evt)
);

// File: tb/hxfer_ctrl_test.sv
`timescale 1ns/1ps
module hxfer_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [2:0]  cpu_addr = 3'd0;
  logic [7:0]  cpu_wdata = 8'h00;
  logic [7:0]  cpu_rdata;
  logic        irq;
  logic        xfer_en;
  logic        buf_rd;
  logic [15:0] buf_addr;
  logic [7:0]  buf_rdata = 8'h00;
  logic        host_drq;
  logic        host_rd = 1'b0;
  logic        host_eop;
  logic [7:0]  host_data;

  int tests = 0;
  int fails = 0;
  int unsigned seed_val;

  always #2 clk = ~clk;

  hxfer_ctrl #(.ADDR_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq(irq), .xfer_en(xfer_en),
    .buf_rd(buf_rd), .buf_addr(buf_addr), .buf_rdata(buf_rdata),
    .host_drq(host_drq), .host_rd(host_rd), .host_eop(host_eop), .host_data(host_data)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5C;
  endfunction

  function automatic logic [15:0] addr_plus(input logic [15:0] a, input int n);
    return 16'((32'(a) + n) % 65536);
  endfunction

  always @(posedge clk) if (buf_rd) buf_rdata <= mem_byte(buf_addr);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic cpu_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    cpu_rd(lo, l);
    cpu_rd(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic load(input logic [15:0] cnt, input logic [15:0] adr);
    cpu_wr(3'd0, cnt[7:0]);
    cpu_wr(3'd1, cnt[15:8]);
    cpu_wr(3'd2, adr[7:0]);
    cpu_wr(3'd3, adr[15:8]);
  endtask

  task automatic clear_irq();
    logic [7:0] st;
    cpu_wr(3'd5, 8'h01);
    cpu_rd(3'd5, st);
    check(st[1] == 1'b1 && irq, "R8 irq held after write without clear bit", st, 8'h02);
    cpu_wr(3'd5, 8'h02);
    cpu_rd(3'd5, st);
    check(st[1] == 1'b0 && !irq, "R8 irq cleared by write with bit1", st, 8'h00);
  endtask

  task automatic run_xfer(input int cnt, input logic [15:0] adr, input int maxw, input bit poke);
    logic [15:0] v;
    logic [7:0]  st;
    int waited;
    load(16'(cnt), adr);
    cpu_wr(3'd4, 8'h01);
    check(xfer_en == 1'b1, "R2 xfer_en after start", xfer_en, 1);
    for (int i = 0; i < cnt; i++) begin
      waited = 0;
      while (!host_drq && waited < 8) begin
        @(negedge clk);
        waited++;
      end
      if (i == 0) check(waited <= 3, "R2 drq latency", waited, 3);
      check(host_drq == 1'b1, "R4 drq present for remaining bytes", host_drq, 1);
      if (poke && i == 0) begin
        cpu_wr(3'd0, 8'h77);
        cpu_wr(3'd2, 8'h10);
        cpu_wr(3'd4, 8'h01);
        rd16(3'd0, v);
        check(v == 16'(cnt), "R9 count unchanged by busy writes", v, cnt);
        rd16(3'd2, v);
        check(v == adr, "R9 address unchanged by busy writes", v, adr);
        @(negedge clk);
      end
      check(host_data == mem_byte(addr_plus(adr, i)), "R3 host_data byte",
            host_data, mem_byte(addr_plus(adr, i)));
      check(host_eop == 1'b0, "R6 eop low without strobe", host_eop, 0);
      for (int g = 0; g < int'($urandom % 3); g++) @(negedge clk);
      host_rd = 1'b1;
      for (int k = 0; k < 1 + int'($urandom % maxw); k++) begin
        @(negedge clk);
        check(host_drq == 1'b0, "R4 drq low during strobe", host_drq, 0);
        check(host_eop == (i == cnt - 1), "R6 eop during strobe", host_eop, i == cnt - 1);
        check(host_data == mem_byte(addr_plus(adr, i)), "R3 data held in strobe",
              host_data, mem_byte(addr_plus(adr, i)));
      end
      host_rd = 1'b0;
      @(negedge clk);
      if (i == cnt - 1) begin
        check(irq == 1'b1 && xfer_en == 1'b0, "R7 flags after last strobe", {irq, xfer_en}, 2'b10);
        check(host_eop == 1'b0, "R6 eop low after last strobe", host_eop, 0);
      end
      rd16(3'd0, v);
      check(v == 16'(cnt - i - 1), "R5 count step", v, cnt - i - 1);
      rd16(3'd2, v);
      check(v == addr_plus(adr, i + 1), "R5 address step", v, addr_plus(adr, i + 1));
    end
    cpu_rd(3'd5, st);
    check(st[1:0] == 2'b10, "R7 status after completion", st, 8'h02);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(host_drq == 1'b0, "R4 no drq after last byte", host_drq, 0);
    end
    clear_irq();
  endtask

  initial begin
    #600000;
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  st;
    seed_val = $urandom(32'h1A2B);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!host_drq && !host_eop && !xfer_en && !irq, "R1 reset outputs",
          {host_drq, host_eop, xfer_en, irq}, 0);
    rd16(3'd0, v);
    check(v == 16'd0, "R1 reset count", v, 0);
    rd16(3'd2, v);
    check(v == 16'd0, "R1 reset address", v, 0);

    // R10 zero count
    load(16'd0, 16'h1234);
    cpu_wr(3'd4, 8'h01);
    check(irq == 1'b1 && xfer_en == 1'b0, "R10 zero count completes", {irq, xfer_en}, 2'b10);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(host_drq == 1'b0, "R10 no drq on zero count", host_drq, 0);
    end
    clear_irq();

    // directed: single byte, wrap, busy pokes
    run_xfer(1, 16'h0100, 1, 1'b0);
    run_xfer(5, 16'hFFFD, 2, 1'b0);
    run_xfer(3, 16'h0040, 3, 1'b1);

    // random transfers
    for (int t = 0; t < 12; t++) begin
      run_xfer(1 + int'($urandom % 9), 16'($urandom), 3, 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule